// File: doc/BRIEF.md
# UART line status and FIFO tracker

This block keeps the line status of a 16550-style UART and owns the receive and transmit FIFOs behind it. A receiver shifter hands it one strobe per finished character. Each strobe carries the byte and three flags: parity error, framing error and break. The byte is queued together with its own flags. A flag becomes visible in the status register only while its character is the oldest one in the queue. If the queue is full, the incoming character is thrown away and an overrun is flagged at once.

On the transmit side, the CPU writes bytes into a transmit FIFO. A transmit shifter takes them one at a time. The block reports when the transmit path has drained. The CPU port offers a data register at address 0, an interrupt enable register at address 1 and the status register at address 5. A read of the status register clears every error indication. Two interrupt outputs follow the status bits, each gated by its own enable bit.

Top module: `uart_lsr_tracker`

## Requirements
- R1: After reset the status register reads 0x20, the enable register reads 0x00 and both interrupt outputs are 0.
- R2: Status bit 0 is 1 exactly while the receive FIFO holds a character. A read at address 0 returns the oldest byte and removes it. Status bits 7 and 6 always read 0.
- R3: Status bit 4 (break), bit 3 (framing) and bit 2 (parity) show the flags stored with the character at the head of the receive FIFO. After that character is read out, the next character's flags are shown from the following cycle.
- R4: When the 16-entry receive FIFO is full and another character completes, that character is discarded and status bit 1 (overrun) reads 1 from the next cycle.
- R5: A status read clears bits 4 to 1 from the next cycle. The head character's flags stay hidden until the head changes.
- R6: An error event in the same cycle as a status read survives the read. This covers both an overrun and a flagged character landing at the head of an empty FIFO.
- R7: A write at address 0 queues a byte for transmission and clears status bit 5 in the next cycle. The shifter receives the bytes in write order. Bit 5 sets again once the shifter takes the last queued byte.
- R8: The transmit-empty interrupt equals enable bit 1 AND status bit 5.
- R9: The line-status interrupt equals enable bit 2 AND (OR of status bits 4 to 1), so it falls after a status read.
- R10: A write to address 5 changes nothing in the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_done_i | input | 1 | Receiver shifter finished a character |
| rx_data_i | input | 8 | Received byte |
| rx_perr_i | input | 1 | Parity error of that character |
| rx_ferr_i | input | 1 | Stop bit sampled low |
| rx_brk_i | input | 1 | Line held low longer than one frame |
| cpu_rd_i | input | 1 | Register read strobe |
| cpu_wr_i | input | 1 | Register write strobe |
| cpu_addr_i | input | 3 | Register address |
| cpu_wdata_i | input | 8 | Write data |
| cpu_rdata_o | output | 8 | Read data, valid in the read cycle |
| tx_load_i | input | 1 | Transmit shifter takes the head byte |
| tx_valid_o | output | 1 | Transmit FIFO holds a byte |
| tx_data_o | output | 8 | Head byte of the transmit FIFO |
| irq_rls_o | output | 1 | Line-status interrupt |
| irq_thre_o | output | 1 | Transmit-empty interrupt |

## Verification
On every cycle, the assertions check four things. A FIFO never grows past its depth and holds still when pushed while full. An overrun event sets the overrun bit. A status read with no concurrent receive clears bits 4 to 1. A status write or a transmit write has its required effect on bit 5 and on the other status bits.

Some behaviours show only in the bench's scenarios, because they span many cycles. These are:
- flags travelling with their own character through the queue;
- the 17th character being really dropped;
- a read event and an error event colliding in one cycle;
- transmit byte order;
- the interrupt gating.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;
  localparam int DATA_W = 8;
  localparam logic [2:0] ADDR_DATA = 3'd0;
  localparam logic [2:0] ADDR_IER  = 3'd1;
  localparam logic [2:0] ADDR_LSR  = 3'd5;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [DATA_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/lsr_sync_fifo.sv
module lsr_sync_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);
  assign rdata_o = mem_q[rd_ptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  a_r4_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> $stable(cnt_q));
endmodule

// File: rtl/lsr_status.sv
module lsr_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_lsr_i,
  input  logic       ovr_evt_i,
  input  logic       head_new_i,
  input  logic       rx_empty_i,
  input  logic [2:0] head_flags_i,  // {brk, ferr, perr}
  input  logic       tx_empty_i,
  input  logic       en_thre_i,
  input  logic       en_rls_i,
  output logic [7:0] lsr_o,
  output logic       irq_rls_o,
  output logic       irq_thre_o
);
  logic       oe_q;
  logic       mask_q;   // head flags already reported
  logic [2:0] flags_vis;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q   <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (ovr_evt_i)     oe_q <= 1'b1;
      else if (rd_lsr_i) oe_q <= 1'b0;
      if (head_new_i)    mask_q <= 1'b0;
      else if (rd_lsr_i) mask_q <= 1'b1;
    end
  end

  assign flags_vis  = (!rx_empty_i && !mask_q) ? head_flags_i : 3'b000;
  assign lsr_o      = {2'b00, tx_empty_i, flags_vis, oe_q, !rx_empty_i};
  assign irq_rls_o  = en_rls_i && (|lsr_o[4:1]);
  assign irq_thre_o = en_thre_i && lsr_o[5];

  a_r4_overrun_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_evt_i |=> lsr_o[1]);
  a_r6_overrun_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_evt_i && rd_lsr_i) |=> oe_q);
endmodule

// File: rtl/uart_lsr_tracker.sv
module uart_lsr_tracker
  import uart_lsr_pkg::*;
#(
  parameter int RX_DEPTH = 16,
  parameter int TX_DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_perr_i,
  input  logic              rx_ferr_i,
  input  logic              rx_brk_i,
  input  logic              cpu_rd_i,
  input  logic              cpu_wr_i,
  input  logic [2:0]        cpu_addr_i,
  input  logic [7:0]        cpu_wdata_i,
  output logic [7:0]        cpu_rdata_o,
  input  logic              tx_load_i,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              irq_rls_o,
  output logic              irq_thre_o
);
  localparam int ENT_W = $bits(rx_entry_t);

  rx_entry_t   rx_in, rx_head;
  logic        rx_empty, rx_full, tx_empty, tx_full;
  logic        rx_pop, rd_lsr, tx_push, ovr_evt, head_new;
  logic [7:0]  ier_q, lsr;

  assign rx_in   = '{brk: rx_brk_i, ferr: rx_ferr_i, perr: rx_perr_i, data: rx_data_i};
  assign rx_pop  = cpu_rd_i && (cpu_addr_i == ADDR_DATA);
  assign rd_lsr  = cpu_rd_i && (cpu_addr_i == ADDR_LSR);
  assign tx_push = cpu_wr_i && (cpu_addr_i == ADDR_DATA);
  assign ovr_evt = rx_done_i && rx_full && !rx_pop;
  assign head_new = (rx_pop && !rx_empty) || (rx_done_i && rx_empty);

  lsr_sync_fifo #(.WIDTH(ENT_W), .DEPTH(RX_DEPTH)) i_rx_fifo (
    .clk_i, .rst_ni,
    .push_i (rx_done_i), .pop_i (rx_pop),
    .wdata_i(rx_in),     .rdata_o(rx_head),
    .empty_o(rx_empty),  .full_o (rx_full)
  );

  lsr_sync_fifo #(.WIDTH(DATA_W), .DEPTH(TX_DEPTH)) i_tx_fifo (
    .clk_i, .rst_ni,
    .push_i (tx_push),     .pop_i (tx_load_i),
    .wdata_i(cpu_wdata_i), .rdata_o(tx_data_o),
    .empty_o(tx_empty),    .full_o (tx_full)
  );

  lsr_status i_status (
    .clk_i, .rst_ni,
    .rd_lsr_i    (rd_lsr),
    .ovr_evt_i   (ovr_evt),
    .head_new_i  (head_new),
    .rx_empty_i  (rx_empty),
    .head_flags_i({rx_head.brk, rx_head.ferr, rx_head.perr}),
    .tx_empty_i  (tx_empty),
    .en_thre_i   (ier_q[1]),
    .en_rls_i    (ier_q[2]),
    .lsr_o       (lsr),
    .irq_rls_o   (irq_rls_o),
    .irq_thre_o  (irq_thre_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     ier_q <= '0;
    else if (cpu_wr_i && (cpu_addr_i == ADDR_IER))   ier_q <= cpu_wdata_i;
  end

  assign tx_valid_o = !tx_empty;

  always_comb begin
    cpu_rdata_o = '0;
    if (cpu_rd_i) begin
      unique case (cpu_addr_i)
        ADDR_DATA: cpu_rdata_o = rx_empty ? '0 : rx_head.data;
        ADDR_IER:  cpu_rdata_o = ier_q;
        ADDR_LSR:  cpu_rdata_o = lsr;
        default:   cpu_rdata_o = '0;
      endcase
    end
  end

  a_r5_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_lsr && !rx_done_i) |=> (lsr[4:1] == 4'b0000));
  a_r7_thr_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_push && !tx_full) |=> !lsr[5]);
  a_r10_write_null: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && cpu_addr_i == ADDR_LSR && !cpu_rd_i && !rx_done_i && !tx_load_i)
    |=> $stable(lsr));
endmodule

// File: tb/test_uart_lsr_tracker.sv
module test_uart_lsr_tracker;
  logic       clk = 0, rst_n = 0;
  logic       rx_done = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0;
  logic [7:0] rx_data = 0;
  logic       rd = 0, wr = 0, tx_load = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata, tx_data;
  logic       tx_valid, irq_rls, irq_thre;
  int         checks = 0, errors = 0;
  bit         done = 0;
  logic [7:0] d;

  always #4 clk = ~clk;  // 125 MHz

  uart_lsr_tracker i_uart_lsr_tracker (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_done_i(rx_done), .rx_data_i(rx_data), .rx_perr_i(rx_perr),
    .rx_ferr_i(rx_ferr), .rx_brk_i(rx_brk),
    .cpu_rd_i(rd), .cpu_wr_i(wr), .cpu_addr_i(addr), .cpu_wdata_i(wdata),
    .cpu_rdata_o(rdata), .tx_load_i(tx_load), .tx_valid_o(tx_valid),
    .tx_data_o(tx_data), .irq_rls_o(irq_rls), .irq_thre_o(irq_thre)
  );

  // {brk, ferr, perr, data}
  localparam logic [10:0] RX_VEC [4] = '{
    {3'b000, 8'h41}, {3'b001, 8'h42}, {3'b010, 8'h43}, {3'b100, 8'h44}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rx_char(input logic [10:0] e);
    @(negedge clk);
    rx_done = 1; {rx_brk, rx_ferr, rx_perr, rx_data} = e;
    @(posedge clk); #1 rx_done = 0;
  endtask

  task automatic cpu_read(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    rd = 1; addr = a;
    #1 v = rdata;
    @(posedge clk); #1 rd = 0;
  endtask

  task automatic cpu_write(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk);
    wr = 1; addr = a; wdata = v;
    @(posedge clk); #1 wr = 0;
  endtask

  task automatic tx_take();
    @(negedge clk);
    tx_load = 1;
    @(posedge clk); #1 tx_load = 0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    cpu_read(3'd5, d); chk("R1 lsr reset", d, 8'h20);
    cpu_read(3'd1, d); chk("R1 ier reset", d, 8'h00);
    chk("R1 irqs reset", {6'b0, irq_rls, irq_thre}, 8'h00);

    // table walk: flags travel with their character
    foreach (RX_VEC[i]) rx_char(RX_VEC[i]);
    for (int i = 0; i < 4; i++) begin
      cpu_read(3'd5, d); chk("R3 head flags", d, 8'h21 | {3'b0, RX_VEC[i][10:8], 2'b0});
      cpu_read(3'd0, d); chk("R2 rx data", d, RX_VEC[i][7:0]);
    end
    cpu_read(3'd5, d); chk("R2 empty", d, 8'h20);

    // R5 read clears and head stays masked
    rx_char({3'b001, 8'h10});
    cpu_read(3'd5, d); chk("R5 first read", d, 8'h25);
    cpu_read(3'd5, d); chk("R5 masked", d, 8'h21);
    cpu_read(3'd0, d); chk("R5 data", d, 8'h10);

    // R3 next char's flags after pop
    rx_char({3'b000, 8'h11});
    rx_char({3'b010, 8'h12});
    cpu_read(3'd5, d); chk("R3 clean head", d, 8'h21);
    cpu_read(3'd0, d);
    cpu_read(3'd5, d); chk("R3 next head", d, 8'h29);
    cpu_read(3'd0, d); chk("R3 data", d, 8'h12);

    // R10 status write ignored
    rx_char({3'b100, 8'h13});
    cpu_write(3'd5, 8'h00);
    cpu_read(3'd5, d); chk("R10 write ignored", d, 8'h31);
    cpu_read(3'd0, d);
    cpu_write(3'd5, 8'hFF);
    cpu_read(3'd5, d); chk("R10 write ignored empty", d, 8'h20);

    // R9 line status interrupt
    cpu_write(3'd1, 8'h04);
    rx_char({3'b001, 8'h14});
    chk("R9 irq_rls on", {7'b0, irq_rls}, 8'h01);
    chk("R8 thre masked", {7'b0, irq_thre}, 8'h00);
    cpu_read(3'd5, d);
    chk("R9 irq_rls off", {7'b0, irq_rls}, 8'h00);
    cpu_read(3'd0, d);

    // R7/R8 transmit side
    cpu_write(3'd1, 8'h02);
    cpu_read(3'd1, d); chk("R8 ier readback", d, 8'h02);
    chk("R8 irq_thre on", {7'b0, irq_thre}, 8'h01);
    cpu_write(3'd0, 8'hA5);
    cpu_write(3'd0, 8'h5A);
    chk("R8 irq_thre off", {7'b0, irq_thre}, 8'h00);
    cpu_read(3'd5, d); chk("R7 thre clear", d, 8'h00);
    chk("R7 tx first", tx_data, 8'hA5);
    tx_take();
    chk("R7 tx second", tx_data, 8'h5A);
    cpu_read(3'd5, d); chk("R7 thre still clear", d, 8'h00);
    tx_take();
    cpu_read(3'd5, d); chk("R7 thre set", d, 8'h20);
    chk("R8 irq_thre back", {7'b0, irq_thre}, 8'h01);
    chk("R7 tx_valid idle", {7'b0, tx_valid}, 8'h00);

    // R4 overrun
    for (int i = 0; i < 16; i++) rx_char({3'b000, 8'(8'h80 + i)});
    cpu_read(3'd5, d); chk("R4 full no ovr", d, 8'h21);
    rx_char({3'b000, 8'hEE});
    cpu_read(3'd5, d); chk("R4 ovr set", d, 8'h23);
    cpu_read(3'd5, d); chk("R5 ovr cleared", d, 8'h21);
    for (int i = 0; i < 16; i++) begin
      cpu_read(3'd0, d); chk("R4 kept data", d, 8'(8'h80 + i));
    end
    cpu_read(3'd5, d); chk("R4 dropped char", d, 8'h20);

    // R6 overrun in read cycle wins
    for (int i = 0; i < 16; i++) rx_char({3'b000, 8'(i)});
    @(negedge clk);
    rx_done = 1; {rx_brk, rx_ferr, rx_perr, rx_data} = {3'b000, 8'h77};
    rd = 1; addr = 3'd5;
    #1 chk("R6 read before ovr", rdata, 8'h21);
    @(posedge clk); #1 begin rd = 0; rx_done = 0; end
    cpu_read(3'd5, d); chk("R6 ovr survives", d, 8'h23);
    for (int i = 0; i < 16; i++) cpu_read(3'd0, d);

    // R6 flagged char lands on empty FIFO during read
    @(negedge clk);
    rx_done = 1; {rx_brk, rx_ferr, rx_perr, rx_data} = {3'b010, 8'h55};
    rd = 1; addr = 3'd5;
    @(posedge clk); #1 begin rd = 0; rx_done = 0; end
    cpu_read(3'd5, d); chk("R6 head flag survives", d, 8'h29);
    cpu_read(3'd0, d); chk("R6 data", d, 8'h55);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule